// File: doc/BRIEF.md
# Hash Accelerator Control Front-End

This block is the register, interrupt and data-port front end placed ahead of a hash core that supports several algorithms. Software uses a 32-bit register bank to program the message length in bits, the algorithm and the byte order of the input words. Writing the control register arms a new message. Data words then arrive on a separate write port. Each accepted word is reordered byte by byte and passed on to the core with a valid strobe, a count of valid bytes and a last flag. When the core reports completion, the block loads the digest into a result queue and raises the new-results status. Software then pops the queue one word per read.

The compression logic is not part of this block. It sits behind a stub interface: start pulse, algorithm code, data words, done strobe and a wide digest bus. The block also flags two protocol errors as interrupt status: data written when no message is open, and reads of an empty result queue.

The sequencer has five states:
- **IDLE**: not armed.
- **HOLD**: the post-arm hold-off window.
- **FEED**: accepting message words.
- **EMPTY**: one cycle that closes a zero-length message.
- **WAIT**: waiting for the core to finish.

Transitions:
- **arm**: a control write moves any state to HOLD.
- **hold_done**: HOLD moves to FEED, or to EMPTY when the length is zero.
- **final_word**: FEED moves to WAIT when the word that reaches the length is accepted.
- **empty_close**: EMPTY moves to WAIT.
- **core_finish**: WAIT moves to IDLE on `core_done`.
- **soft_reset**: a held soft reset returns the sequencer to IDLE.

Top module: `hashfe_top`

## Requirements
- R1: After `rst_n` is released, the status and control registers read 0, `irq` is 0 and `dat_ready` is 1.
- R2: The length-high (0x4) and length-low (0x8) registers read back the written value. Control (0xC) reads back only bits [1:0] and [9:8]. Interrupt enable (0x14) reads back only bits [3:0].
- R3: Writing 1 to offset 0x0 holds the block in reset. While held, 0x0 reads 1, and control, length, enables, status, queue and sequencer are all cleared. Writing 0 releases the hold.
- R4: A control write pulses `core_start` in the next cycle, with `core_algo` equal to control bits [1:0] (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256). `dat_ready` stays low for the two cycles after the write cycle. A data word held on the port in that window is not forwarded until the window ends.
- R5: Control bits [9:8] reorder each accepted word, listing output bytes from most to least significant in terms of input byte indices (byte 3 = bits 31:24): 0 gives 3,2,1,0; 1 gives 0,1,2,3; 2 gives 2,3,1,0; 3 gives 1,0,3,2.
- R6: The number of message bytes is the bit length rounded up to whole bytes. Each forwarded word has `core_bytes` = min(4, bytes remaining) and is valid from the most significant byte down. Unused low bytes of `core_data` are 0. `core_last` is high with the word that uses up the count.
- R7: With a zero message length, `core_last` pulses alone (without `core_valid`) in the first cycle after the hold-off.
- R8: A data write while idle, after the last word, or while waiting for the core is not forwarded (`core_valid` stays 0) and sets status bit 3.
- R9: `core_done` while waiting loads the queue with 4 (MD5), 5 (SHA-1), 7 (SHA-224) or 8 (SHA-256) digest words and sets status bit 1. Status bit 0 reads 1 while the queue holds words.
- R10: Each read of offset 0x1C pops one word, starting with digest word N-1 (bits [32N-1:32N-32] of `core_digest`) and ending with word 0.
- R11: A read of 0x1C with the queue empty returns 0 and sets status bit 2.
- R12: `irq` is the OR of status bits [3:0] ANDed with enable bits [3:0], and status bit 8 reads `irq`. Writing a mask to 0x18 clears status bits 1 to 3. Bit 0 follows the queue contents only.
- R13: `core_done` is ignored when the block is not waiting for the core: no status bit changes and the queue stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the queue at 0x1C) |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of `reg_rd` |
| dat_wr | input | 1 | Data port write strobe |
| dat_wdata | input | 32 | Data port word |
| dat_ready | output | 1 | Low during the hold-off window; the word must be held |
| core_start | output | 1 | One-cycle pulse that opens a message at the core |
| core_algo | output | 2 | Algorithm code to the core |
| core_valid | output | 1 | Forwarded word strobe |
| core_data | output | 32 | Reordered and masked word |
| core_bytes | output | 3 | Valid bytes in `core_data`, 1 to 4 |
| core_last | output | 1 | Final word (or empty-message close) marker |
| core_done | input | 1 | Core completion strobe |
| core_digest | input | 256 | Digest words, word i at bits [32i+31:32i] |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a data word that is already on the port in the cycle the control write lands. It must be held through the whole hold-off and then accepted exactly once, in the first open cycle. The stimulus raises `dat_wr` immediately after the arming write and keeps it up, then checks `core_valid` in each cycle of the window and the cycle after it. A three-word message of nine bytes follows this start. It drives the byte counter through a full word, another full word and a one-byte tail, and then past the end into the write-error path.

// File: rtl/hashfe_pkg.sv
`timescale 1ns/1ps
package hashfe_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ALG_MD5    = 2'd0,
        ALG_SHA1   = 2'd1,
        ALG_SHA224 = 2'd2,
        ALG_SHA256 = 2'd3
    } algo_e;

    typedef enum logic [1:0] {
        ORD_PASS = 2'd0,
        ORD_REV  = 2'd1,
        ORD_MIXA = 2'd2,
        ORD_MIXB = 2'd3
    } order_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_FEED  = 3'd2,
        ST_EMPTY = 3'd3,
        ST_WAIT  = 3'd4
    } fe_state_e;

    // status bit positions
    localparam int STS_AVAIL = 0;
    localparam int STS_NEW   = 1;
    localparam int STS_RDERR = 2;
    localparam int STS_WRERR = 3;
    localparam int STS_SUM   = 8;

    // register word indices (byte offset / 4)
    localparam logic [2:0] RIX_SRST = 3'd0;
    localparam logic [2:0] RIX_LENH = 3'd1;
    localparam logic [2:0] RIX_LENL = 3'd2;
    localparam logic [2:0] RIX_CTRL = 3'd3;
    localparam logic [2:0] RIX_STAT = 3'd4;
    localparam logic [2:0] RIX_IEN  = 3'd5;
    localparam logic [2:0] RIX_ICLR = 3'd6;
    localparam logic [2:0] RIX_RESQ = 3'd7;

    function automatic logic [3:0] digest_words(input logic [1:0] alg);
        unique case (algo_e'(alg))
            ALG_MD5:    digest_words = 4'd4;
            ALG_SHA1:   digest_words = 4'd5;
            ALG_SHA224: digest_words = 4'd7;
            default:    digest_words = 4'd8;
        endcase
    endfunction

    // output bytes listed MSB first by input byte index
    function automatic logic [WORD_W-1:0] reorder(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] ord);
        logic [7:0] b3, b2, b1, b0;
        {b3, b2, b1, b0} = w;
        unique case (order_e'(ord))
            ORD_PASS: reorder = {b3, b2, b1, b0};
            ORD_REV:  reorder = {b0, b1, b2, b3};
            ORD_MIXA: reorder = {b2, b3, b1, b0};
            default:  reorder = {b1, b0, b3, b2};
        endcase
    endfunction

endpackage

// File: rtl/hashfe_regbank.sv
`timescale 1ns/1ps
module hashfe_regbank
    import hashfe_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LEN_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              srst,
    output logic [LEN_W-1:0]  len_bits,
    output logic [1:0]        algo,
    output logic [1:0]        order,
    output logic              arm,
    output logic              pop,
    input  logic              ev_wr_err,
    input  logic              ev_new,
    input  logic              ev_rd_err,
    input  logic              q_empty,
    input  logic [31:0]       q_word,
    output logic              irq
);

    localparam int HALF_W = LEN_W / 2;

    logic [2:0]        idx;
    logic [HALF_W-1:0] len_hi_q, len_lo_q;
    logic [1:0]        algo_q, order_q;
    logic [3:0]        ien_q;
    logic [3:1]        sts_q;
    logic [3:1]        sts_set, sts_clr;
    logic [3:0]        sts_live;
    logic              wr_act;

    assign idx      = reg_addr[4:2];
    assign wr_act   = reg_wr && !srst;
    assign arm      = wr_act && (idx == RIX_CTRL);
    assign pop      = reg_rd && !srst && (idx == RIX_RESQ);
    assign len_bits = {len_hi_q, len_lo_q};
    assign algo     = algo_q;
    assign order    = order_q;

    assign sts_set  = {ev_wr_err, ev_rd_err, ev_new};
    assign sts_clr  = (wr_act && idx == RIX_ICLR) ? reg_wdata[3:1] : 3'b000;
    assign sts_live = {sts_q, !q_empty};
    assign irq      = |(sts_live & ien_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst     <= 1'b0;
            len_hi_q <= '0;
            len_lo_q <= '0;
            algo_q   <= '0;
            order_q  <= '0;
            ien_q    <= '0;
            sts_q    <= '0;
        end else begin
            if (reg_wr && idx == RIX_SRST)
                srst <= reg_wdata[0];
            if (srst) begin
                len_hi_q <= '0;
                len_lo_q <= '0;
                algo_q   <= '0;
                order_q  <= '0;
                ien_q    <= '0;
                sts_q    <= '0;
            end else begin
                if (wr_act) begin
                    unique case (idx)
                        RIX_LENH: len_hi_q <= reg_wdata[HALF_W-1:0];
                        RIX_LENL: len_lo_q <= reg_wdata[HALF_W-1:0];
                        RIX_CTRL: begin
                            algo_q  <= reg_wdata[1:0];
                            order_q <= reg_wdata[9:8];
                        end
                        RIX_IEN:  ien_q <= reg_wdata[3:0];
                        default:  ;
                    endcase
                end
                sts_q <= (sts_q & ~sts_clr) | sts_set;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (idx)
            RIX_SRST: reg_rdata = {31'd0, srst};
            RIX_LENH: reg_rdata = len_hi_q;
            RIX_LENL: reg_rdata = len_lo_q;
            RIX_CTRL: reg_rdata = {22'd0, order_q, 6'd0, algo_q};
            RIX_STAT: reg_rdata = {23'd0, irq, 4'd0, sts_live};
            RIX_IEN:  reg_rdata = {28'd0, ien_q};
            RIX_RESQ: reg_rdata = q_word;
            default:  reg_rdata = '0;
        endcase
    end

    // R12
    new_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !srst && idx == RIX_ICLR && reg_wdata[STS_NEW] && !ev_new)
        |=> !sts_q[STS_NEW]);

    // R3
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (sts_q == '0 && ien_q == '0 && algo_q == '0 && len_lo_q == '0));

endmodule

// File: rtl/hashfe_ingress.sv
`timescale 1ns/1ps
module hashfe_ingress
    import hashfe_pkg::*;
#(
    parameter int HOLD_CYC = 2,
    parameter int LEN_W    = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             arm,
    input  logic [LEN_W-1:0] len_bits,
    input  logic [1:0]       order,
    input  logic             dat_wr,
    input  logic [31:0]      dat_wdata,
    output logic             dat_ready,
    output logic             core_start,
    output logic             core_valid,
    output logic [31:0]      core_data,
    output logic [2:0]       core_bytes,
    output logic             core_last,
    input  logic             core_done,
    output logic             ev_wr_err,
    output logic             q_load
);

    localparam int REM_W = LEN_W - 2;
    localparam int HC_W  = $clog2(HOLD_CYC + 1);
    localparam logic [HC_W-1:0] HOLD_END = HC_W'(HOLD_CYC - 1);

    fe_state_e         state_q, state_d;
    logic [HC_W-1:0]   hold_q;
    logic [REM_W-1:0]  rem_q;
    logic [REM_W-1:0]  len_bytes;
    logic [2:0]        take;
    logic              is_last;
    logic              accept;
    logic [31:0]       swz;

    assign len_bytes = REM_W'(len_bits[LEN_W-1:3]) + REM_W'(|len_bits[2:0]);
    assign take      = (rem_q >= REM_W'(4)) ? 3'd4 : rem_q[2:0];
    assign is_last   = (rem_q <= REM_W'(4));
    assign accept    = dat_wr && (state_q == ST_FEED);

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_IDLE;
            ST_HOLD:  if (hold_q == HOLD_END)
                          state_d = (rem_q == '0) ? ST_EMPTY : ST_FEED;
            ST_FEED:  if (accept && is_last) state_d = ST_WAIT;
            ST_EMPTY: state_d = ST_WAIT;
            ST_WAIT:  if (core_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (arm) state_d = ST_HOLD;
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            rem_q   <= '0;
        end else if (clr) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            if (arm) begin
                hold_q <= '0;
                rem_q  <= len_bytes;
            end else begin
                if (state_q == ST_HOLD) hold_q <= hold_q + 1'b1;
                if (accept)             rem_q  <= rem_q - REM_W'(take);
            end
        end
    end

    // outputs
    always_comb begin
        swz        = reorder(dat_wdata, order);
        dat_ready  = (state_q != ST_HOLD);
        core_start = (state_q == ST_HOLD) && (hold_q == '0);
        core_valid = accept;
        core_bytes = accept ? take : 3'd0;
        core_last  = (accept && is_last) || (state_q == ST_EMPTY);
        ev_wr_err  = dat_wr && ((state_q == ST_IDLE) || (state_q == ST_WAIT) ||
                                (state_q == ST_EMPTY));
        q_load     = (state_q == ST_WAIT) && core_done;
        core_data  = '0;
        for (int b = 0; b < 4; b++) begin
            if (3'(b) < take)
                core_data[8*(3-b) +: 8] = swz[8*(3-b) +: 8];
        end
    end

    // R4
    hold_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_valid);

    // R6
    byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid |-> (core_bytes != 3'd0 && core_bytes <= 3'd4));

    // R7
    last_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_last |=> !core_valid);

    // R8
    err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wr_err |-> !core_valid);

endmodule

// File: rtl/hashfe_resq.sv
`timescale 1ns/1ps
module hashfe_resq #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       load,
    input  logic [$clog2(DEPTH+1)-1:0] load_n,
    input  logic [DEPTH*W-1:0]         load_data,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       empty,
    output logic                       rd_err
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] top_idx;

    assign empty   = (cnt_q == '0);
    assign top_idx = IDX_W'(cnt_q - 1'b1);
    assign rdata   = empty ? '0 : mem[top_idx];
    assign rd_err  = pop && empty;

    always_ff @(posedge clk) begin
        if (load) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= load_data[i*W +: W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_n;
        else if (pop && !empty)
            cnt_q <= cnt_q - 1'b1;
    end

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !load) |=> empty);

    // R9
    load_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (cnt_q == $past(load_n)));

endmodule

// File: rtl/hashfe_top.sv
`timescale 1ns/1ps
module hashfe_top
    import hashfe_pkg::*;
#(
    parameter int HOLD_CYC = 2,
    parameter int Q_DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [4:0]              reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic                    dat_wr,
    input  logic [31:0]             dat_wdata,
    output logic                    dat_ready,
    output logic                    core_start,
    output logic [1:0]              core_algo,
    output logic                    core_valid,
    output logic [31:0]             core_data,
    output logic [2:0]              core_bytes,
    output logic                    core_last,
    input  logic                    core_done,
    input  logic [Q_DEPTH*32-1:0]   core_digest,
    output logic                    irq
);

    localparam int LEN_W = 64;
    localparam int CNT_W = $clog2(Q_DEPTH + 1);

    logic             srst, arm, pop;
    logic [LEN_W-1:0] len_bits;
    logic [1:0]       algo, order;
    logic             ev_wr_err, ev_rd_err, q_load, q_empty;
    logic [31:0]      q_word;
    logic [CNT_W-1:0] load_n;

    assign core_algo = algo;
    assign load_n    = CNT_W'(digest_words(algo));

    hashfe_regbank #(.ADDR_W(5), .LEN_W(LEN_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .srst      (srst),
        .len_bits  (len_bits),
        .algo      (algo),
        .order     (order),
        .arm       (arm),
        .pop       (pop),
        .ev_wr_err (ev_wr_err),
        .ev_new    (q_load),
        .ev_rd_err (ev_rd_err),
        .q_empty   (q_empty),
        .q_word    (q_word),
        .irq       (irq)
    );

    hashfe_ingress #(.HOLD_CYC(HOLD_CYC), .LEN_W(LEN_W)) u_ingress (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (srst),
        .arm        (arm),
        .len_bits   (len_bits),
        .order      (order),
        .dat_wr     (dat_wr),
        .dat_wdata  (dat_wdata),
        .dat_ready  (dat_ready),
        .core_start (core_start),
        .core_valid (core_valid),
        .core_data  (core_data),
        .core_bytes (core_bytes),
        .core_last  (core_last),
        .core_done  (core_done),
        .ev_wr_err  (ev_wr_err),
        .q_load     (q_load)
    );

    hashfe_resq #(.DEPTH(Q_DEPTH), .W(32)) u_resq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst),
        .load      (q_load),
        .load_n    (load_n),
        .load_data (core_digest),
        .pop       (pop),
        .rdata     (q_word),
        .empty     (q_empty),
        .rd_err    (ev_rd_err)
    );

endmodule

// File: tb/hashfe_top_tb.sv
`timescale 1ns/1ps
module hashfe_top_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         dat_wr = 1'b0;
    logic [31:0]  dat_wdata = '0;
    logic         dat_ready, core_start, core_valid, core_last, irq;
    logic [1:0]   core_algo;
    logic [31:0]  core_data;
    logic [2:0]   core_bytes;
    logic         core_done = 1'b0;
    logic [255:0] core_digest = '0;

    int nvec = 0;
    int nmis = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hashfe_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_ready(dat_ready),
        .core_start(core_start), .core_algo(core_algo), .core_valid(core_valid),
        .core_data(core_data), .core_bytes(core_bytes), .core_last(core_last),
        .core_done(core_done), .core_digest(core_digest), .irq(irq)
    );

    // {order, bit length, expected core_data, expected core_bytes}; input word A1B2C3D4
    localparam logic [55:0] VEC [8] = '{
        {8'd0, 8'd32, 32'hA1B2C3D4, 8'd4},
        {8'd1, 8'd32, 32'hD4C3B2A1, 8'd4},
        {8'd2, 8'd32, 32'hB2A1C3D4, 8'd4},
        {8'd3, 8'd32, 32'hC3D4A1B2, 8'd4},
        {8'd0, 8'd8,  32'hA1000000, 8'd1},
        {8'd1, 8'd17, 32'hD4C3B200, 8'd3},
        {8'd2, 8'd24, 32'hB2A1C300, 8'd3},
        {8'd3, 8'd12, 32'hC3D40000, 8'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nmis++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse_done(input logic [31:0] base);
        for (int k = 0; k < 8; k++) core_digest[32*k +: 32] = base + 32'(k);
        @(negedge clk);
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nmis++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(5'h10, r); chk("R1 status", r, 32'h0);
        rd_reg(5'h0C, r); chk("R1 control", r, 32'h0);
        #1 chk("R1 irq", irq, 0); chk("R1 dat_ready", dat_ready, 1);

        // R13 done while idle is ignored
        pulse_done(32'hEEEE0000);
        rd_reg(5'h10, r); chk("R13 status", r, 32'h0);

        // R8 idle write, R12 clear
        @(negedge clk); dat_wr = 1'b1; dat_wdata = 32'h12345678;
        #1 chk("R8 idle valid", core_valid, 0);
        @(negedge clk); dat_wr = 1'b0;
        rd_reg(5'h10, r); chk("R8 status", r, 32'h8);
        wr_reg(5'h18, 32'h8);
        rd_reg(5'h10, r); chk("R12 clear", r, 32'h0);

        // R2 readback
        wr_reg(5'h04, 32'hDEADBEEF); rd_reg(5'h04, r); chk("R2 lenhi", r, 32'hDEADBEEF);
        wr_reg(5'h08, 32'h12345678); rd_reg(5'h08, r); chk("R2 lenlo", r, 32'h12345678);
        wr_reg(5'h0C, 32'hFFFFFFFF); rd_reg(5'h0C, r); chk("R2 control", r, 32'h303);
        wr_reg(5'h14, 32'hFFFFFFFF); rd_reg(5'h14, r); chk("R2 enable", r, 32'hF);

        // R3 soft reset
        wr_reg(5'h00, 32'h1);
        rd_reg(5'h00, r); chk("R3 held", r, 32'h1);
        rd_reg(5'h0C, r); chk("R3 control", r, 32'h0);
        rd_reg(5'h04, r); chk("R3 lenhi", r, 32'h0);
        rd_reg(5'h14, r); chk("R3 enable", r, 32'h0);
        wr_reg(5'h00, 32'h0);
        rd_reg(5'h00, r); chk("R3 released", r, 32'h0);

        // R4 R5 R6 vector table
        for (int i = 0; i < 8; i++) begin
            logic [1:0] ord;
            ord = VEC[i][49:48];
            wr_reg(5'h08, {24'd0, VEC[i][47:40]});
            wr_reg(5'h0C, {22'd0, ord, 6'd0, ord});
            #1 chk("R4 start", core_start, 1);
            chk("R4 algo", core_algo, ord);
            chk("R4 ready0", dat_ready, 0);
            @(negedge clk); #1 chk("R4 ready1", dat_ready, 0);
            @(negedge clk); #1 chk("R4 ready2", dat_ready, 1);
            dat_wr = 1'b1; dat_wdata = 32'hA1B2C3D4;
            #1 chk("R5 data", core_data, VEC[i][39:8]);
            chk("R6 bytes", core_bytes, VEC[i][2:0]);
            chk("R6 last", core_last, 1);
            @(negedge clk); dat_wr = 1'b0;
        end

        // R4 stall then R6 multi-word message (9 bytes), R8 overrun
        wr_reg(5'h08, 32'd72);
        wr_reg(5'h0C, 32'h3);
        dat_wr = 1'b1; dat_wdata = 32'h11223344;
        #1 chk("R4 stall a", core_valid, 0);
        @(negedge clk); #1 chk("R4 stall b", core_valid, 0);
        @(negedge clk); #1 chk("R4 accept", core_valid, 1);
        chk("R6 w0 data", core_data, 32'h11223344);
        chk("R6 w0 last", core_last, 0);
        @(negedge clk); dat_wdata = 32'h55667788;
        #1 chk("R6 w1 bytes", core_bytes, 4); chk("R6 w1 last", core_last, 0);
        @(negedge clk); dat_wdata = 32'h99AABBCC;
        #1 chk("R6 w2 data", core_data, 32'h99000000);
        chk("R6 w2 bytes", core_bytes, 1); chk("R6 w2 last", core_last, 1);
        @(negedge clk); dat_wdata = 32'h00000BAD;
        #1 chk("R8 overrun valid", core_valid, 0);
        @(negedge clk); dat_wr = 1'b0;
        rd_reg(5'h10, r); chk("R8 overrun status", r, 32'h8);

        // R9 R10 R11 R12
        pulse_done(32'h10000000);
        rd_reg(5'h10, r); chk("R9 status", r, 32'hB);
        wr_reg(5'h18, 32'hE);
        rd_reg(5'h10, r); chk("R12 avail kept", r, 32'h1);
        for (int k = 0; k < 8; k++) begin
            rd_reg(5'h1C, r); chk("R10 pop", r, 32'h10000007 - 32'(k));
        end
        rd_reg(5'h1C, r); chk("R11 empty data", r, 32'h0);
        rd_reg(5'h10, r); chk("R11 status", r, 32'h4);
        wr_reg(5'h14, 32'h4);
        #1 chk("R12 irq on", irq, 1);
        rd_reg(5'h10, r); chk("R12 sum bit", r, 32'h104);
        wr_reg(5'h18, 32'h4);
        #1 chk("R12 irq off", irq, 0);
        rd_reg(5'h10, r); chk("R12 cleared", r, 32'h0);

        // R7 and R9 per algorithm
        for (int a = 0; a < 4; a++) begin
            logic [31:0] nw;
            nw = (a == 0) ? 4 : (a == 1) ? 5 : (a == 2) ? 7 : 8;
            wr_reg(5'h08, 32'h0);
            wr_reg(5'h0C, 32'(a));
            @(negedge clk);
            @(negedge clk);
            #1 if (a == 0) begin
                chk("R7 last alone", core_last, 1);
                chk("R7 no valid", core_valid, 0);
            end
            pulse_done(32'h000000D0);
            rd_reg(5'h1C, r); chk("R9 first word", r, 32'h000000D0 + nw - 1);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
        $finish;
    end

endmodule